// File: doc/BRIEF.md
# In-Order Issue Controller with Register and Write-Port Reservations

This block is the issue stage of a pipeline that issues instructions strictly in program order while its function units complete out of order. Three fixed-latency pipelined function units (1, 3 and 6 cycles) share a single register write port. Each cycle the controller is offered one decoded instruction: a unit select, a destination register and two source registers. It either issues the instruction or holds it until every hazard has cleared.

Two kinds of reservation state drive the decision. Each of the eight registers has a pending-write bit. The bit is set when an instruction that targets the register issues, and it is cleared when that write returns. A set bit on a source means a read-after-write hazard. A set bit on the destination means a write-after-write hazard. The shared write port has a shifting slot vector. An instruction whose unit has latency L claims the slot L cycles ahead, and it may issue only if that slot is free. On issue, the operands are read from the register file and sent to the selected unit in a one-cycle pulse that also carries the destination tag. The units return results as writeback events. These events write the register file and release the destination's pending bit.

Top module: `inorder_issue_ctrl`

## Requirements
- R1: After synchronous reset, `in_ready` is high, `issue_valid` is low, no register or write-port slot is reserved, and every register reads as zero.
- R2: An instruction accepted at a clock edge (`in_valid` and `in_ready` both high) produces `issue_valid` high for exactly the following cycle. In that cycle `issue_fu` and `issue_dst` echo the request, and `issue_opa` and `issue_opb` hold the register-file values of `in_src_a` and `in_src_b`. Hazard-free instructions issue one per cycle.
- R3: If either source register has a pending write, the instruction is held until that writeback has been written. It then issues with the newly written value. No bypass exists, so a dependant of a latency-L producer that issued the cycle before waits L cycles.
- R4: If the destination register has a pending write, the instruction is held until that write completes.
- R5: Writing a register that an older issued instruction reads causes no stall. The older instruction's operand keeps the value read at its issue.
- R6: Unit select 0, 1 and 2 have latencies 1, 3 and 6, and values above 2 are not used. An instruction whose write-port slot (issue edge plus its latency) is already claimed is held until the slot is free.
- R7: Completion may be out of order. A short-latency instruction issued after a long one can write back, and its dependants can issue, while the long one is still in flight.
- R8: While an offered instruction is held, `issue_valid` stays low. The held instruction issues unchanged once its hazards clear.
- R9: A writeback (`wb_valid`, `wb_dst`, `wb_data`) arrives exactly in the reserved port slot, for a register with a pending write. At that edge it writes `wb_data` and clears the register's pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | No hazard; the offered instruction issues at this edge |
| in_fu | input | 2 | Function-unit select (0: 1 cycle, 1: 3 cycles, 2: 6 cycles) |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| issue_valid | output | 1 | One-cycle pulse that dispatches to a function unit |
| issue_fu | output | 2 | Selected function unit |
| issue_dst | output | 3 | Destination tag carried to the unit |
| issue_opa | output | 16 | First operand value |
| issue_opb | output | 16 | Second operand value |
| wb_valid | input | 1 | A function unit writes back this cycle |
| wb_dst | input | 3 | Register written back |
| wb_data | input | 16 | Value written back |

## Verification
The bound checker checks the per-cycle rules on every cycle. No accepted instruction has a pending source or destination, and none lands on a claimed write-port slot. Every issue pulse follows an acceptance and tags a reserved register. Every writeback falls in slot zero of the port vector and targets a reserved register. Only the directed scenarios can show the timing end to end: the exact stall length for each producer latency, the operand values actually delivered after a RAW wait, the absence of stalls and the stale operand value for WAR, and a short operation finishing and feeding a dependant while a long one is still in flight.

// File: rtl/iss_pkg.sv
`timescale 1ns/10ps
package iss_pkg;
    localparam int NREG    = 8;
    localparam int REG_AW  = $clog2(NREG);
    localparam int DATA_W  = 16;
    localparam int NUM_FU  = 3;
    localparam int FU_W    = $clog2(NUM_FU + 1);
    localparam int MAX_LAT = 6;
    localparam int RSV_W   = MAX_LAT + 1;
    localparam int RSV_IW  = $clog2(RSV_W);

    typedef logic [REG_AW-1:0] reg_idx_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [FU_W-1:0]   fu_sel_t;

    typedef struct packed {
        fu_sel_t  fu;
        reg_idx_t dst;
        reg_idx_t src_a;
        reg_idx_t src_b;
    } instr_t;

    typedef struct packed {
        fu_sel_t  fu;
        reg_idx_t dst;
        data_t    opa;
        data_t    opb;
    } dispatch_t;

    // Fixed pipeline depth of each function unit, in cycles.
    function automatic logic [RSV_IW-1:0] fu_latency(fu_sel_t sel);
        case (sel)
            fu_sel_t'(0): fu_latency = RSV_IW'(1);
            fu_sel_t'(1): fu_latency = RSV_IW'(3);
            default:      fu_latency = RSV_IW'(MAX_LAT);
        endcase
    endfunction
endpackage

// File: rtl/iss_port_rsv.sv
`timescale 1ns/10ps
// Shifting slot vector for the shared write port. Bit i set means a
// writeback lands at the (i+1)-th upcoming clock edge.
module iss_port_rsv #(
    parameter int W  = iss_pkg::RSV_W,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] slot,
    input  logic          claim,
    output logic          slot_busy,
    output logic [W-1:0]  rsv_q
);
    logic [W-1:0] claim_vec;

    always_comb begin
        claim_vec = '0;
        if (claim) claim_vec = W'(1) << slot;
    end

    assign slot_busy = rsv_q[slot];

    always_ff @(posedge clk) begin
        if (rst) rsv_q <= '0;
        else     rsv_q <= (rsv_q | claim_vec) >> 1;
    end
endmodule

// File: rtl/iss_reg_busy.sv
`timescale 1ns/10ps
// One pending-write bit per architectural register.
module iss_reg_busy #(
    parameter int N  = iss_pkg::NREG,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    output logic [N-1:0]  busy_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                                   busy_q[i] <= 1'b0;
            else if (set_en && set_idx == AW'(i))      busy_q[i] <= 1'b1;
            else if (clr_en && clr_idx == AW'(i))      busy_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/iss_regfile.sv
`timescale 1ns/10ps
// Register file: one write port (writeback), two read ports (issue).
module iss_regfile #(
    parameter int N  = iss_pkg::NREG,
    parameter int AW = $clog2(N),
    parameter int DW = iss_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                          regs_q[i] <= '0;
            else if (we && waddr == AW'(i))   regs_q[i] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/inorder_issue_ctrl.sv
`timescale 1ns/10ps
module inorder_issue_ctrl
    import iss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FU_W-1:0]   in_fu,
    input  logic [REG_AW-1:0] in_dst,
    input  logic [REG_AW-1:0] in_src_a,
    input  logic [REG_AW-1:0] in_src_b,
    output logic              issue_valid,
    output logic [FU_W-1:0]   issue_fu,
    output logic [REG_AW-1:0] issue_dst,
    output logic [DATA_W-1:0] issue_opa,
    output logic [DATA_W-1:0] issue_opb,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [DATA_W-1:0] wb_data
);
    instr_t            req;
    dispatch_t         disp_q;
    logic [NREG-1:0]   busy_q;
    logic [RSV_W-1:0]  rsv_q;
    logic [RSV_IW-1:0] req_lat;
    logic              port_conflict;
    logic              raw_hazard;
    logic              waw_hazard;
    logic              fire;
    data_t             rd_a;
    data_t             rd_b;

    assign req     = '{fu: in_fu, dst: in_dst, src_a: in_src_a, src_b: in_src_b};
    assign req_lat = fu_latency(req.fu);

    iss_reg_busy #(.N(NREG), .AW(REG_AW)) busy_i (
        .clk     (clk),
        .rst     (rst),
        .set_en  (fire),
        .set_idx (req.dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_dst),
        .busy_q  (busy_q)
    );

    iss_port_rsv #(.W(RSV_W), .IW(RSV_IW)) port_i (
        .clk       (clk),
        .rst       (rst),
        .slot      (req_lat),
        .claim     (fire),
        .slot_busy (port_conflict),
        .rsv_q     (rsv_q)
    );

    iss_regfile #(.N(NREG), .AW(REG_AW), .DW(DATA_W)) rf_i (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_valid),
        .waddr   (wb_dst),
        .wdata   (wb_data),
        .raddr_a (req.src_a),
        .raddr_b (req.src_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // WAR needs no term: operands are read here, in order, at issue.
    assign raw_hazard = busy_q[req.src_a] | busy_q[req.src_b];
    assign waw_hazard = busy_q[req.dst];
    assign in_ready   = !(raw_hazard || waw_hazard || port_conflict);
    assign fire       = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_valid <= 1'b0;
            disp_q      <= '0;
        end else begin
            issue_valid <= fire;
            if (fire) disp_q <= '{fu: req.fu, dst: req.dst, opa: rd_a, opb: rd_b};
        end
    end

    assign issue_fu  = disp_q.fu;
    assign issue_dst = disp_q.dst;
    assign issue_opa = disp_q.opa;
    assign issue_opb = disp_q.opb;
endmodule

// File: rtl/inorder_issue_ctrl_chk.sv
`timescale 1ns/10ps
module inorder_issue_ctrl_chk
    import iss_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [FU_W-1:0]   in_fu,
    input logic [REG_AW-1:0] in_dst,
    input logic [REG_AW-1:0] in_src_a,
    input logic [REG_AW-1:0] in_src_b,
    input logic              issue_valid,
    input logic [REG_AW-1:0] issue_dst,
    input logic              wb_valid,
    input logic [REG_AW-1:0] wb_dst,
    input logic [NREG-1:0]   busy,
    input logic [RSV_W-1:0]  port_rsv
);
    logic              accept;
    logic [RSV_IW-1:0] lat_c;

    assign accept = in_valid && in_ready;
    assign lat_c  = fu_latency(in_fu);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!issue_valid && busy == '0 && port_rsv == '0));

    assert_issue_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> $past(accept));

    assert_no_raw_R3: assert property (@(posedge clk) disable iff (rst)
        accept |-> (!busy[in_src_a] && !busy[in_src_b]));

    assert_no_waw_R4: assert property (@(posedge clk) disable iff (rst)
        accept |-> !busy[in_dst]);

    assert_fu_range_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (int'(in_fu) < NUM_FU));

    assert_port_free_R6: assert property (@(posedge clk) disable iff (rst)
        accept |-> !port_rsv[lat_c]);

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> !issue_valid);

    assert_wb_slot_R9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (port_rsv[0] && busy[wb_dst]));

    assert_dst_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> busy[issue_dst]);
endmodule

bind inorder_issue_ctrl inorder_issue_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_fu       (in_fu),
    .in_dst      (in_dst),
    .in_src_a    (in_src_a),
    .in_src_b    (in_src_b),
    .issue_valid (issue_valid),
    .issue_dst   (issue_dst),
    .wb_valid    (wb_valid),
    .wb_dst      (wb_dst),
    .busy        (busy_q),
    .port_rsv    (rsv_q)
);

// File: tb/inorder_issue_ctrl_tb_top.sv
`timescale 1ns/10ps
module inorder_issue_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fu = '0;
    logic [2:0]  in_dst = '0;
    logic [2:0]  in_src_a = '0;
    logic [2:0]  in_src_b = '0;
    logic        issue_valid;
    logic [1:0]  issue_fu;
    logic [2:0]  issue_dst;
    logic [15:0] issue_opa;
    logic [15:0] issue_opb;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_dst = '0;
    logic [15:0] wb_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    // Function-unit model state and the bench's own view of the registers.
    logic        sch_v [16];
    logic [2:0]  sch_d [16];
    logic [15:0] sch_x [16];
    logic [15:0] shadow [8];
    int          cyc = 0;

    always #2 clk = ~clk;

    inorder_issue_ctrl dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_fu(in_fu), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .issue_valid(issue_valid), .issue_fu(issue_fu), .issue_dst(issue_dst),
        .issue_opa(issue_opa), .issue_opb(issue_opb),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
    );

    function automatic int unit_lat(input logic [1:0] f);
        case (f)
            2'd0:    return 1;
            2'd1:    return 3;
            default: return 6;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Function units: a dispatch seen after edge E returns its result at
    // edge E+latency; data is opa + opb + select + 1.
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) sch_v[i] = 1'b0;
            for (int i = 0; i < 8; i++) shadow[i] = '0;
            wb_valid = 1'b0;
            cyc = 0;
        end else begin
            if (issue_valid) begin
                int s;
                s = (cyc + unit_lat(issue_fu) - 1) % 16;
                sch_v[s] = 1'b1;
                sch_d[s] = issue_dst;
                sch_x[s] = issue_opa + issue_opb + 16'(issue_fu) + 16'd1;
            end
            wb_valid = sch_v[cyc % 16];
            wb_dst   = sch_d[cyc % 16];
            wb_data  = sch_x[cyc % 16];
            if (wb_valid) shadow[wb_dst] = wb_data;
            sch_v[cyc % 16] = 1'b0;
            cyc++;
        end
    end

    // Offer one instruction, wait for it to issue, check the dispatch pulse.
    task automatic send(input logic [1:0] f, input logic [2:0] d,
                        input logic [2:0] sa, input logic [2:0] sb,
                        input string req, output int waited);
        logic [15:0] ea, eb;
        in_valid = 1'b1; in_fu = f; in_dst = d; in_src_a = sa; in_src_b = sb;
        waited = 0;
        #0.1;
        while (!in_ready && waited < 40) begin
            @(negedge clk); #0.5;
            check(!issue_valid, "R8", "issue_valid while held", int'(issue_valid), 0);
            waited++;
        end
        ea = shadow[sa];
        eb = shadow[sb];
        @(posedge clk); #0.5;
        in_valid = 1'b0;
        @(negedge clk); #0.5;
        check(issue_valid, req, "issue pulse", int'(issue_valid), 1);
        check(issue_fu == f && issue_dst == d, req, "dispatch tag",
              int'({issue_fu, issue_dst}), int'({f, d}));
        check(issue_opa == ea, req, "operand a", int'(issue_opa), int'(ea));
        check(issue_opb == eb, req, "operand b", int'(issue_opb), int'(eb));
    endtask

    task automatic drain();
        repeat (10) @(negedge clk);
        #0.5;
    endtask

    task automatic t_reset();
        int w;
        @(negedge clk); #0.5;
        check(in_ready, "R1", "ready after reset", int'(in_ready), 1);
        check(!issue_valid, "R1", "issue_valid after reset", int'(issue_valid), 0);
        send(2'd0, 3'd7, 3'd3, 3'd4, "R1", w);
        check(issue_opa == 16'd0 && issue_opb == 16'd0, "R1", "zero registers",
              int'(issue_opa), 0);
        drain();
    endtask

    task automatic t_independent();
        int w;
        send(2'd0, 3'd1, 3'd7, 3'd7, "R2", w);
        check(w == 0, "R2", "stall of first", w, 0);
        send(2'd1, 3'd2, 3'd7, 3'd0, "R2", w);
        check(w == 0, "R2", "stall of second", w, 0);
        send(2'd2, 3'd3, 3'd5, 3'd6, "R2", w);
        check(w == 0, "R2", "stall of third", w, 0);
        drain();
    endtask

    task automatic t_raw();
        int w;
        send(2'd2, 3'd1, 3'd2, 3'd7, "R3", w);
        send(2'd0, 3'd4, 3'd1, 3'd0, "R3", w);
        check(w == 6, "R3", "RAW wait behind latency 6", w, 6);
        send(2'd1, 3'd5, 3'd4, 3'd4, "R3", w);
        check(w == 1, "R3", "RAW wait behind latency 1", w, 1);
        drain();
    endtask

    task automatic t_waw();
        int w;
        send(2'd1, 3'd5, 3'd0, 3'd1, "R4", w);
        send(2'd0, 3'd5, 3'd6, 3'd6, "R4", w);
        check(w == 3, "R4", "WAW wait behind latency 3", w, 3);
        drain();
    endtask

    task automatic t_war();
        int w;
        logic [15:0] old5;
        old5 = shadow[5];
        send(2'd2, 3'd6, 3'd5, 3'd2, "R5", w);
        check(issue_opa == old5, "R5", "old value read", int'(issue_opa), int'(old5));
        send(2'd0, 3'd5, 3'd0, 3'd1, "R5", w);
        check(w == 0, "R5", "WAR causes no stall", w, 0);
        drain();
    endtask

    task automatic t_struct();
        int w;
        send(2'd1, 3'd1, 3'd0, 3'd0, "R6", w);
        send(2'd0, 3'd2, 3'd3, 3'd3, "R6", w);
        send(2'd0, 3'd3, 3'd4, 3'd4, "R6", w);
        check(w == 1, "R6", "port slot clash 3 vs 1", w, 1);
        drain();
        send(2'd2, 3'd1, 3'd0, 3'd0, "R6", w);
        send(2'd0, 3'd2, 3'd5, 3'd5, "R6", w);
        send(2'd0, 3'd3, 3'd5, 3'd5, "R6", w);
        send(2'd1, 3'd4, 3'd5, 3'd5, "R6", w);
        check(w == 1, "R6", "port slot clash 6 vs 3", w, 1);
        drain();
    endtask

    task automatic t_ooo();
        int w;
        send(2'd2, 3'd1, 3'd6, 3'd7, "R7", w);
        send(2'd0, 3'd2, 3'd3, 3'd4, "R7", w);
        check(w == 0, "R7", "short op issues behind long", w, 0);
        send(2'd0, 3'd3, 3'd2, 3'd2, "R7", w);
        check(w == 1, "R7", "dependant of short op before long completes", w, 1);
        send(2'd0, 3'd4, 3'd1, 3'd3, "R7", w);
        check(w == 3, "R7", "dependant of long op", w, 3);
        drain();
    endtask

    task automatic t_wb_regfile();
        int w;
        logic [15:0] v;
        send(2'd1, 3'd6, 3'd2, 3'd3, "R9", w);
        v = shadow[2] + shadow[3] + 16'd2;
        send(2'd0, 3'd7, 3'd6, 3'd6, "R9", w);
        check(issue_opa == v, "R9", "written-back value read", int'(issue_opa), int'(v));
        check(w == 3, "R9", "pending bit released at writeback", w, 3);
        drain();
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        t_reset();
        t_independent();
        t_raw();
        t_waw();
        t_war();
        t_struct();
        t_ooo();
        t_wb_regfile();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule